// File: doc/BRIEF.md
# Variable-Length Field Packer with External SRAM Ring Buffer

The block takes a stream of variable-length code fields. Each field is a value together with a count of how many of its low bits are valid. The block joins these fields bit after bit, most significant bit first, and cuts the result into bytes. Each finished byte goes into an external byte-wide SRAM that serves as a ring buffer for transmission. A downstream transmitter takes bytes back out of that buffer by raising a read request. The block owns the write and read pointers and the fill count. It decides which access uses the single SRAM port in each cycle, and it drives the address, chip enables, write strobe, output enable and the bidirectional data bus.

The buffer can be one device of `2^ADDR_W` bytes, or two devices that give twice that space. In the two-device mode the pointers carry one extra bit, and that bit picks which chip enable is driven. An early warning rises once the number of stored bytes reaches a threshold set by software. When the buffer is completely full, the field input is held off. A flush request closes the current partial byte by appending zero bits, and the stuffing output marks that fill. With the default `ADDR_W` of 15, the SRAM address is 15 bits wide.

Top module: `vlc_pack_sram`

## Requirements
- R1: Accepted fields are joined bit after bit, most significant valid bit first, in the order they were accepted. The downstream reader receives the resulting bytes in the same order, first bit in bit 7, with no bits lost or repeated.
- R2: A field length from 0 to FRAG_W (16) is legal. Only the low `frag_len` bits of `frag_data` are used. A length of 0 adds no bits.
- R3: A field is accepted on a clock edge where `frag_valid` and `frag_ready` are both high. `frag_ready` is low while eight or more bits are held, while a flush is pending, and while the buffer is full.
- R4: With `two_chip` = 1 the buffer holds 2^(ADDR_W+1) bytes. Pointer bit ADDR_W = 0 drives `sram_ce1_n` low and bit ADDR_W = 1 drives `sram_ce2_n` low. The low ADDR_W bits form `sram_addr`.
- R5: With `two_chip` = 0 the buffer holds 2^ADDR_W bytes. `sram_ce2_n` stays high at all times.
- R6: A waiting byte is written whenever the buffer is not full, and it takes the port ahead of any read. A read is granted only when `rd_req` is high, the buffer is not empty, and no write takes that cycle. `sram_we_n` and `sram_oe_n` are never low together.
- R7: A read granted in cycle n, marked by `sram_oe_n` low, gives `rd_valid` high with the byte on `rd_data` in cycle n+1. Each grant gives exactly one `rd_valid` pulse.
- R8: `ovf_warn` is high exactly when the number of stored bytes is greater than or equal to `ovf_thresh`.
- R9: When the stored byte count equals the capacity, no field is accepted until a read frees space.
- R10: A `flush_req` pulse pads the bits held at that point up to a whole byte with zero bits. `stuff_active` is high during the cycle in which that padded byte is written. A flush with no partial byte held raises no stuffing.
- R11: During reset and in the first cycle after it: `frag_ready` = 1, `rd_valid` = 0, `stuff_active` = 0, `ovf_warn` = 0 when `ovf_thresh` > 0, and all four SRAM strobes are high.
- R12: In a cycle with no access, both chip enables, `sram_we_n` and `sram_oe_n` are high and the data bus is released. In a cycle with an access, exactly one chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| two_chip | input | 1 | 1 = two-device buffer, 0 = one device |
| ovf_thresh | input | ADDR_W+2 | Fill level at which the overflow warning rises |
| frag_valid | input | 1 | A field is offered |
| frag_data | input | FRAG_W | Field value, right-aligned |
| frag_len | input | LEN_W | Number of valid bits, 0 to FRAG_W |
| frag_ready | output | 1 | The field is taken on this edge if valid |
| flush_req | input | 1 | Pulse: close the current partial byte |
| stuff_active | output | 1 | High while a zero-padded byte is being written |
| rd_req | input | 1 | The transmitter wants a byte this cycle |
| rd_valid | output | 1 | `rd_data` holds a byte read from the buffer |
| rd_data | output | 8 | Byte read from the buffer |
| ovf_warn | output | 1 | Fill level is at or above the threshold |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dq | inout | 8 | SRAM data bus |
| sram_ce1_n | output | 1 | First device enable, active low |
| sram_ce2_n | output | 1 | Second device enable, active low |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The properties assume that `two_chip` and `ovf_thresh` change only while reset is held. They also assume that `frag_len` never exceeds FRAG_W, and that the external memory drives `sram_dq` only while `sram_oe_n` is low and `sram_we_n` is high. The bench changes the mode and the threshold only inside its reset task and keeps random lengths in the range 0 to 16. Its memory model drives the bus only under that read condition. It keeps each device in a separate array, so a byte sent to the wrong chip shows up as wrong read data.

// File: rtl/vlc_pack_pkg.sv
// Package: types shared by the field packer and its SRAM buffer control.
// Assumes: the SRAM is byte wide.
package vlc_pack_pkg;
    localparam int BYTE_W = 8;

    // Kind of SRAM access chosen for the current cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/vlc_pack_accum.sv
// Module: joins right-aligned fields into a left-aligned accumulator and
// offers the top byte whenever eight or more bits are held.
// Assumes: ACC_W >= FRAG_W + 7, and frag_len <= FRAG_W (larger values are clamped).
// An accept and a byte removal never fall in the same cycle: accepting needs
// fewer than eight held bits, and removal needs eight or more.
module vlc_pack_accum
    import vlc_pack_pkg::*;
#(
    parameter int FRAG_W = 16,
    parameter int LEN_W  = 5,
    parameter int ACC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frag_valid,
    input  logic [FRAG_W-1:0] frag_data,
    input  logic [LEN_W-1:0]  frag_len,
    input  logic              flush_req,
    input  logic              space_ok,
    input  logic              byte_taken,
    output logic              frag_ready,
    output logic              byte_pend,
    output logic [BYTE_W-1:0] byte_out,
    output logic              stuff_active
);
    localparam int CNT_W = $clog2(ACC_W + 1);
    localparam int SH_W  = CNT_W + 1;

    logic [ACC_W-1:0]  acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flush_q;
    logic              stuff_q;
    logic [LEN_W-1:0]  eff_len;
    logic [FRAG_W:0]   one_sh;
    logic [FRAG_W-1:0] len_mask;
    logic [SH_W-1:0]   place_sh;
    logic [ACC_W-1:0]  placed;
    logic              accept;
    logic              pad_now;

    // Readiness and the byte offered to the buffer.
    always_comb begin
        byte_pend  = (cnt_q >= CNT_W'(BYTE_W));
        frag_ready = !byte_pend && !flush_q && space_ok;
        byte_out   = acc_q[ACC_W-1 -: BYTE_W];
        accept     = frag_valid && frag_ready;
        pad_now    = flush_q && (cnt_q != '0) && !byte_pend;
    end

    // Mask the field to its valid bits and place it just after the held bits.
    always_comb begin
        eff_len  = (frag_len > LEN_W'(FRAG_W)) ? LEN_W'(FRAG_W) : frag_len;
        one_sh   = (FRAG_W+1)'(1) << eff_len;
        len_mask = one_sh[FRAG_W-1:0] - 1'b1;
        place_sh = SH_W'(ACC_W) - {1'b0, cnt_q} - SH_W'(eff_len);
        placed   = ACC_W'(frag_data & len_mask) << place_sh;
    end

    // Accumulator contents and held bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            acc_q <= acc_q | placed;
            cnt_q <= cnt_q + CNT_W'(eff_len);
        end else if (byte_taken) begin
            acc_q <= acc_q << BYTE_W;
            cnt_q <= cnt_q - CNT_W'(BYTE_W);
        end else if (pad_now) begin
            cnt_q <= CNT_W'(BYTE_W);
        end
    end

    // Flush pending flag: set on request, cleared once nothing is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else if (!flush_q) begin
            flush_q <= flush_req;
        end else if (cnt_q == '0) begin
            flush_q <= 1'b0;
        end
    end

    // Stuffing marker: from the pad until the padded byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuff_q <= 1'b0;
        end else if (pad_now) begin
            stuff_q <= 1'b1;
        end else if (byte_taken) begin
            stuff_q <= 1'b0;
        end
    end

    assign stuff_active = stuff_q;
endmodule

// File: rtl/vlc_pack_ring.sv
// Module: write and read pointers, fill count, full, empty and overflow warning
// for an SRAM ring buffer of one or two devices.
// Assumes: two_chip and ovf_thresh change only while reset is held.
module vlc_pack_ring #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              two_chip,
    input  logic [ADDR_W+1:0] ovf_thresh,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic              full,
    output logic              empty,
    output logic              ovf_warn
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int CNT_W = ADDR_W + 2;

    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] cap;
    logic [PTR_W-1:0] ptr_q [2];
    logic             adv   [2];

    // Advance a pointer; in the one-device mode it wraps below the select bit.
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                 input logic dual);
        logic [PTR_W-1:0] n;
        n = p + 1'b1;
        if (!dual) n[PTR_W-1] = 1'b0;
        return n;
    endfunction

    // Which pointer advances: index 0 is the write side, index 1 the read side.
    always_comb begin
        adv[0] = wr_en;
        adv[1] = rd_en;
    end

    // One register per pointer.
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (adv[g]) begin
                ptr_q[g] <= step_ptr(ptr_q[g], two_chip);
            end
        end
    end

    // Stored byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (wr_en && !rd_en) begin
            fill_q <= fill_q + 1'b1;
        end else if (rd_en && !wr_en) begin
            fill_q <= fill_q - 1'b1;
        end
    end

    // Capacity and level flags.
    always_comb begin
        cap      = two_chip ? (CNT_W'(1) << (ADDR_W + 1)) : (CNT_W'(1) << ADDR_W);
        full     = (fill_q == cap);
        empty    = (fill_q == '0);
        ovf_warn = (fill_q >= ovf_thresh);
        wr_ptr   = ptr_q[0];
        rd_ptr   = ptr_q[1];
    end
endmodule

// File: rtl/vlc_pack_arb.sv
// Module: chooses the single SRAM access of each cycle (write ahead of read),
// drives the SRAM pins, and registers the read data.
// Assumes: the SRAM drives data combinationally while enabled for reading,
// and takes a write on the clock edge that ends a cycle with the write strobe low.
module vlc_pack_arb
    import vlc_pack_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              two_chip,
    input  logic              byte_pend,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              full,
    input  logic              empty,
    input  logic              rd_req,
    input  logic [ADDR_W:0]   wr_ptr,
    input  logic [ADDR_W:0]   rd_ptr,
    input  logic [BYTE_W-1:0] dq_in,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    acc_kind_e       kind;
    logic [ADDR_W:0] sel_ptr;
    logic            hi_chip;
    logic            active;

    // Pick the access: a waiting byte wins; a read needs a free port and stored data.
    always_comb begin
        if (byte_pend && !full) begin
            kind = ACC_WRITE;
        end else if (rd_req && !empty) begin
            kind = ACC_READ;
        end else begin
            kind = ACC_IDLE;
        end
    end

    // Drive the pins for the chosen access.
    always_comb begin
        wr_en     = (kind == ACC_WRITE);
        rd_en     = (kind == ACC_READ);
        active    = wr_en || rd_en;
        sel_ptr   = wr_en ? wr_ptr : rd_ptr;
        hi_chip   = two_chip && sel_ptr[ADDR_W];
        sram_addr = sel_ptr[ADDR_W-1:0];
        ce1_n     = !(active && !hi_chip);
        ce2_n     = !(active && hi_chip);
        we_n      = !wr_en;
        oe_n      = !rd_en;
        dq_out    = byte_in;
        dq_oe     = wr_en;
    end

    // Capture the read byte at the end of the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/vlc_pack_sram.sv
// Module: top of the field packer. It ties the accumulator, the ring pointers
// and the SRAM port arbiter together and owns the tri-state data bus.
// Assumes: one clock, synchronous active-low reset, and an external SRAM
// (one or two devices) on the sram_* pins.
module vlc_pack_sram
    import vlc_pack_pkg::*;
#(
    parameter int FRAG_W = 16,
    parameter int LEN_W  = 5,
    parameter int ACC_W  = 24,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              two_chip,
    input  logic [ADDR_W+1:0] ovf_thresh,
    input  logic              frag_valid,
    input  logic [FRAG_W-1:0] frag_data,
    input  logic [LEN_W-1:0]  frag_len,
    output logic              frag_ready,
    input  logic              flush_req,
    output logic              stuff_active,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              ovf_warn,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [7:0]        sram_dq,
    output logic              sram_ce1_n,
    output logic              sram_ce2_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    logic              byte_pend_w;
    logic [BYTE_W-1:0] byte_w;
    logic              wr_en_w;
    logic              rd_en_w;
    logic              full_w;
    logic              empty_w;
    logic [ADDR_W:0]   wr_ptr_w;
    logic [ADDR_W:0]   rd_ptr_w;
    logic [BYTE_W-1:0] dq_out_w;
    logic              dq_oe_w;

    vlc_pack_accum #(
        .FRAG_W(FRAG_W),
        .LEN_W (LEN_W),
        .ACC_W (ACC_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .frag_valid  (frag_valid),
        .frag_data   (frag_data),
        .frag_len    (frag_len),
        .flush_req   (flush_req),
        .space_ok    (!full_w),
        .byte_taken  (wr_en_w),
        .frag_ready  (frag_ready),
        .byte_pend   (byte_pend_w),
        .byte_out    (byte_w),
        .stuff_active(stuff_active)
    );

    vlc_pack_ring #(
        .ADDR_W(ADDR_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .two_chip  (two_chip),
        .ovf_thresh(ovf_thresh),
        .wr_en     (wr_en_w),
        .rd_en     (rd_en_w),
        .wr_ptr    (wr_ptr_w),
        .rd_ptr    (rd_ptr_w),
        .full      (full_w),
        .empty     (empty_w),
        .ovf_warn  (ovf_warn)
    );

    vlc_pack_arb #(
        .ADDR_W(ADDR_W)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .two_chip (two_chip),
        .byte_pend(byte_pend_w),
        .byte_in  (byte_w),
        .full     (full_w),
        .empty    (empty_w),
        .rd_req   (rd_req),
        .wr_ptr   (wr_ptr_w),
        .rd_ptr   (rd_ptr_w),
        .dq_in    (sram_dq),
        .wr_en    (wr_en_w),
        .rd_en    (rd_en_w),
        .sram_addr(sram_addr),
        .ce1_n    (sram_ce1_n),
        .ce2_n    (sram_ce2_n),
        .we_n     (sram_we_n),
        .oe_n     (sram_oe_n),
        .dq_out   (dq_out_w),
        .dq_oe    (dq_oe_w),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Data bus is driven only during a write.
    assign sram_dq = dq_oe_w ? dq_out_w : 8'hzz;
endmodule

// File: rtl/vlc_pack_sram_chk.sv
// Module: property checker for vlc_pack_sram, attached by bind below.
// Assumes: two_chip and ovf_thresh change only under reset.
module vlc_pack_sram_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              two_chip,
    input logic [ADDR_W+1:0] ovf_thresh,
    input logic              frag_ready,
    input logic              stuff_active,
    input logic              rd_valid,
    input logic              ovf_warn,
    input logic              sram_ce1_n,
    input logic              sram_ce2_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              full_w
);
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    // R5
    single_ce2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !two_chip |-> sram_ce2_n);

    // R4
    one_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || !sram_oe_n) |-> (sram_ce1_n != sram_ce2_n));

    // R12
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we_n && sram_oe_n) |-> (sram_ce1_n && sram_ce2_n));

    // R7
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |=> rd_valid);

    // R7
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!sram_oe_n));

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_w |-> !frag_ready);

    // R3
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !frag_ready);

    // R10
    stuff_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_active && !full_w) |-> !sram_we_n);

    // R8
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_warn) && $stable(ovf_thresh)) |-> $past(!sram_we_n));
endmodule

bind vlc_pack_sram vlc_pack_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .two_chip    (two_chip),
    .ovf_thresh  (ovf_thresh),
    .frag_ready  (frag_ready),
    .stuff_active(stuff_active),
    .rd_valid    (rd_valid),
    .ovf_warn    (ovf_warn),
    .sram_ce1_n  (sram_ce1_n),
    .sram_ce2_n  (sram_ce2_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .full_w      (full_w)
);

// File: tb/vlc_pack_sram_tb.sv
// Bench: directed corner cases plus seeded random traffic against a bit-queue model.
module vlc_pack_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          two_chip = 1'b1;
    logic [AW+1:0] ovf_thresh = 6'd5;
    logic          frag_valid = 1'b0;
    logic [15:0]   frag_data = '0;
    logic [4:0]    frag_len = '0;
    logic          frag_ready;
    logic          flush_req = 1'b0;
    logic          stuff_active;
    logic          rd_req = 1'b0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          ovf_warn;
    logic [AW-1:0] sram_addr;
    wire  [7:0]    sram_dq;
    logic          sram_ce1_n, sram_ce2_n, sram_we_n, sram_oe_n;

    int n_checks = 0;
    int n_errors = 0;
    int rd_mode = 0;
    int rd_cnt = 0, ce2_wr = 0, stuff_cyc = 0, stuff_we = 0, conflicts = 0;
    logic [7:0] last_rd = '0;
    bit   bitq[$];
    logic [7:0] expq[$];
    logic [7:0] mem1 [2**AW];
    logic [7:0] mem2 [2**AW];

    always #(CLK_PERIOD/2) clk = ~clk;

    vlc_pack_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .two_chip(two_chip), .ovf_thresh(ovf_thresh),
        .frag_valid(frag_valid), .frag_data(frag_data), .frag_len(frag_len),
        .frag_ready(frag_ready), .flush_req(flush_req), .stuff_active(stuff_active),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .ovf_warn(ovf_warn),
        .sram_addr(sram_addr), .sram_dq(sram_dq), .sram_ce1_n(sram_ce1_n),
        .sram_ce2_n(sram_ce2_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    // SRAM model: one array per device, synchronous write, combinational read.
    always @(posedge clk) begin
        if (!sram_we_n) begin
            if (!sram_ce1_n) mem1[sram_addr] <= sram_dq;
            if (!sram_ce2_n) mem2[sram_addr] <= sram_dq;
        end
    end
    assign sram_dq = (!sram_oe_n && sram_we_n) ?
                     (!sram_ce2_n ? mem2[sram_addr] : (!sram_ce1_n ? mem1[sram_addr] : 8'hzz))
                     : 8'hzz;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bit-queue model of the packed stream.
    task automatic model_drain();
        while (bitq.size() >= 8) begin
            logic [7:0] b;
            for (int i = 7; i >= 0; i--) b[i] = bitq.pop_front();
            expq.push_back(b);
        end
    endtask

    task automatic model_push(input logic [15:0] d, input int len);
        for (int i = len - 1; i >= 0; i--) bitq.push_back(d[i]);
        model_drain();
    endtask

    task automatic model_flush();
        while (bitq.size() % 8 != 0) bitq.push_back(1'b0);
        model_drain();
    endtask

    // Read port driver and output monitor.
    always @(negedge clk) begin
        rd_req <= (rd_mode == 1) || (rd_mode == 2 && ($urandom % 2 == 1));
        if (rst_n) begin
            if (!sram_we_n && !sram_oe_n) begin
                conflicts++;
                check(1'b0, "R6 strobes", 1, 0);
            end
            if (!sram_we_n && !sram_ce2_n) ce2_wr++;
            if (stuff_active) stuff_cyc++;
            if (stuff_active && !sram_we_n) stuff_we++;
            if (rd_valid) begin
                rd_cnt++;
                last_rd = rd_data;
                if (expq.size() == 0) begin
                    check(1'b0, "R1 unexpected byte", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check(rd_data == e, "R1 byte order", rd_data, e);
                end
            end
        end
    end

    task automatic do_reset(input logic mode, input logic [AW+1:0] th);
        rst_n = 1'b0;
        rd_mode = 0;
        two_chip = mode;
        ovf_thresh = th;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bitq.delete();
        expq.delete();
        rd_cnt = 0; ce2_wr = 0; stuff_cyc = 0; stuff_we = 0;
    endtask

    task automatic send_frag(input logic [15:0] d, input int len);
        frag_data = d;
        frag_len = 5'(len);
        frag_valid = 1'b1;
        while (!frag_ready) @(negedge clk);
        @(negedge clk);
        frag_valid = 1'b0;
        model_push(d, len);
    endtask

    task automatic try_frag(input logic [15:0] d, input int len, output bit ok);
        ok = 1'b0;
        frag_data = d;
        frag_len = 5'(len);
        frag_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (frag_ready) begin
                @(negedge clk);
                ok = 1'b1;
                model_push(d, len);
                break;
            end
            @(negedge clk);
        end
        frag_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        model_flush();
    endtask

    task automatic fill_test(input logic mode, input int cap, input int exp_ce2);
        int acc_n;
        bit ok;
        do_reset(mode, 6'd40);
        acc_n = 0;
        ok = 1'b1;
        while (ok && acc_n < cap + 4) begin
            try_frag(16'(acc_n * 7 + 3), 8, ok);
            if (ok) acc_n++;
        end
        check(acc_n == cap, "R9 accepted before full", acc_n, cap);
        check(frag_ready == 1'b0, "R9 ready while full", frag_ready, 0);
        check(ce2_wr == exp_ce2, mode ? "R4 second chip writes" : "R5 second chip writes",
              ce2_wr, exp_ce2);
        rd_mode = 1;
        repeat (cap + 10) @(negedge clk);
        rd_mode = 0;
        check(rd_cnt == cap, "R7 one byte per grant", rd_cnt, cap);
        check(expq.size() == 0, "R1 drained", expq.size(), 0);
    endtask

    initial begin
        bit ok;
        void'($urandom(32'h5eed_1234));
        do_reset(1'b1, 6'd5);
        // R11 reset state
        check(frag_ready == 1'b1, "R11 frag_ready", frag_ready, 1);
        check(rd_valid == 1'b0, "R11 rd_valid", rd_valid, 0);
        check(stuff_active == 1'b0, "R11 stuff_active", stuff_active, 0);
        check(ovf_warn == 1'b0, "R11 ovf_warn", ovf_warn, 0);
        check({sram_ce1_n, sram_ce2_n, sram_we_n, sram_oe_n} == 4'hf, "R11 strobes",
              {sram_ce1_n, sram_ce2_n, sram_we_n, sram_oe_n}, 4'hf);

        // R2: upper bits masked, zero length adds nothing: 101 + 10011 = B3
        send_frag(16'hFFF5, 3);
        send_frag(16'hFFFF, 0);
        send_frag(16'h0013, 5);
        // R3: a 16-bit field leaves 16 bits held, so ready drops
        send_frag(16'hABCD, 16);
        check(frag_ready == 1'b0, "R3 ready with byte held", frag_ready, 0);
        rd_mode = 1;
        repeat (12) @(negedge clk);
        rd_mode = 0;
        check(rd_cnt == 3, "R2 byte count", rd_cnt, 3);
        check(last_rd == 8'hCD, "R1 last byte", last_rd, 8'hCD);
        check(frag_ready == 1'b1, "R3 ready after drain", frag_ready, 1);

        // R10 flush with a partial byte: 111 -> E0
        stuff_cyc = 0; stuff_we = 0;
        send_frag(16'h0007, 3);
        do_flush();
        repeat (6) @(negedge clk);
        check(stuff_cyc == 1, "R10 stuff cycles", stuff_cyc, 1);
        check(stuff_we == 1, "R10 stuff with write", stuff_we, 1);
        do_flush();
        repeat (6) @(negedge clk);
        check(stuff_cyc == 1, "R10 empty flush", stuff_cyc, 1);
        rd_mode = 1;
        repeat (6) @(negedge clk);
        rd_mode = 0;
        check(last_rd == 8'hE0, "R10 padded byte", last_rd, 8'hE0);

        // R8 threshold
        do_reset(1'b1, 6'd5);
        for (int i = 0; i < 4; i++) send_frag(16'(i), 8);
        repeat (4) @(negedge clk);
        check(ovf_warn == 1'b0, "R8 below threshold", ovf_warn, 0);
        send_frag(16'h55, 8);
        repeat (4) @(negedge clk);
        check(ovf_warn == 1'b1, "R8 at threshold", ovf_warn, 1);
        rd_mode = 1;
        repeat (2) @(negedge clk);
        rd_mode = 0;
        repeat (2) @(negedge clk);
        check(ovf_warn == 1'b0, "R8 after reads", ovf_warn, 0);
        rd_mode = 1;
        repeat (8) @(negedge clk);
        rd_mode = 0;

        // R4 and R9: two devices, 32 bytes; R5: one device, 16 bytes
        fill_test(1'b1, 32, 16);
        fill_test(1'b0, 16, 0);

        // R6 random traffic with random reads and occasional flushes
        do_reset(1'b1, 6'd40);
        conflicts = 0;
        rd_mode = 2;
        for (int i = 0; i < 400; i++) begin
            send_frag(16'($urandom), int'($urandom % 17));
            if ($urandom % 20 == 0) do_flush();
        end
        do_flush();
        rd_mode = 1;
        for (int k = 0; k < 3000 && expq.size() != 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        rd_mode = 0;
        check(expq.size() == 0, "R1 random stream complete", expq.size(), 0);
        check(conflicts == 0, "R6 no strobe overlap", conflicts, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule